// File: doc/BRIEF.md
# Radio Module Power Sequencer

This block sits on the host side of a radio module and owns the module's enable and active-low hard-reset lines. It watches two supply-good indications, one for the battery rail and one for the I/O rail, and accepts single-cycle power-on and power-off requests. On power-up it waits for both rails in the right order and only then raises enable. It holds reset low for a crystal-settling interval counted on its own clock, then releases reset and reports ready one cycle later. On power-down it drops enable and reset together, then waits for the I/O rail to go before the battery rail.

Any break in the supply order sets a sticky error flag. This covers the I/O rail showing good without the battery rail, the battery rail falling ahead of the I/O rail, and either rail failing while the module is enabled. A supply failure while enabled also drives enable and reset low at the very next clock edge. While the module is up, a wake request produces a pulse of fixed width on a wake output, which brings the module out of doze without a reset.

The controller has six states. It sits in OFF until a power-on request moves it to WAIT_SUPPLIES. When both rails are good it moves to ENABLE for one cycle, then to SETTLE while the settle timer counts. At the end of the count it moves to READY. A power-off request from ENABLE, SETTLE or READY goes to POWER_DOWN, which returns to OFF once the I/O rail is gone. A supply fault goes straight to OFF, and so does a power-off request in WAIT_SUPPLIES.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `mod_enable`, `mod_reset_n`, `ready`, `seq_error` and `mod_wake` are all 0. Enable and reset are always driven to a definite 0 or 1.
- R2: In OFF, a `pwr_on_req` moves the controller to WAIT_SUPPLIES. `mod_enable` rises only at the clock edge where the controller is in WAIT_SUPPLIES and samples `batt_good`=1 and `io_good`=1.
- R3: In WAIT_SUPPLIES, sampling `io_good`=1 while `batt_good`=0 sets `seq_error` and returns to OFF with enable still 0.
- R4: `mod_reset_n` rises exactly SETTLE_CYCLES+1 clock cycles after `mod_enable` rises, with SETTLE_CYCLES = (CLK_HZ/1000)*(SETTLE_NS/1000)/1000. The default parameters give 5 ms at 125 MHz. `mod_reset_n` is never 1 while `mod_enable` is 0.
- R5: `ready` rises one cycle after `mod_reset_n` rises and is 1 only while the controller stays in READY.
- R6: In ENABLE, SETTLE or READY, a sample with either supply-good at 0 drives `mod_enable` and `mod_reset_n` low at that edge, sets `seq_error` and goes to OFF. This takes priority over a power-off request in the same cycle.
- R7: In ENABLE, SETTLE or READY, a `pwr_off_req` with both rails good drops `mod_enable` and `mod_reset_n` at the same edge and enters POWER_DOWN without setting `seq_error`.
- R8: POWER_DOWN holds enable and reset low until `io_good` is sampled 0, then goes to OFF. If `batt_good` is sampled 0 while `io_good` is still 1, `seq_error` is set.
- R9: `seq_error` stays 1 until `rst_n` is asserted. A set error does not block a later power-up.
- R10: A `wake_req` sampled while the controller stays in READY and no pulse is running drives `mod_wake` high for exactly WAKE_CYCLES cycles, starting at that edge. Requests during a running pulse, or outside READY, have no effect.
- R11: Leaving READY clears `mod_wake` at the same edge, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| batt_good | input | 1 | Battery rail is within range |
| io_good | input | 1 | I/O rail is within range |
| pwr_on_req | input | 1 | Request to start the power-up order |
| pwr_off_req | input | 1 | Request to start the power-down order |
| wake_req | input | 1 | Request for a wake pulse to the module |
| mod_enable | output | 1 | Module enable, 1 = powered |
| mod_reset_n | output | 1 | Module hard reset, 0 = held in reset |
| mod_wake | output | 1 | Wake pulse to the module |
| ready | output | 1 | Module is out of reset and usable |
| seq_error | output | 1 | Sticky supply-ordering or supply-loss error |

## Verification
A wrong state shows at the enable, reset and ready pins within one clock edge, because all three are registered from the next state. A stuck or mis-set settle counter moves the edge where `mod_reset_n` rises away from SETTLE_CYCLES+1 cycles after enable. A missed fault or ordering check shows as `seq_error` staying 0 at the edge after the offending supply sample. A wake pulse counter that is off by one, or not cleared when READY is left, changes the count of `mod_wake` high cycles or leaves the pulse visible for one cycle after enable has fallen.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        PS_OFF      = 3'd0,
        PS_WAIT_SUP = 3'd1,
        PS_ENABLE   = 3'd2,
        PS_SETTLE   = 3'd3,
        PS_READY    = 3'd4,
        PS_PDOWN    = 3'd5
    } pwr_state_t;

    // States in which the module enable line is driven high.
    function automatic logic state_powered(input pwr_state_t s);
        return (s == PS_ENABLE) || (s == PS_SETTLE) || (s == PS_READY);
    endfunction

    // Converts a clock rate and a settle time into a cycle count, at least one.
    function automatic int settle_count(input int clk_hz, input int settle_ns);
        int c;
        c = ((clk_hz / 1000) * (settle_ns / 1000)) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the count never passes the settle limit
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= LAST));

    // R4: a restart always begins from zero
    assert_count_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/pwr_wake_pulse.sv
module pwr_wake_pulse #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic req,
    output logic pulse
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (!allow) begin
            remain <= '0;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end else if (req) begin
            remain <= CNT_W'(WIDTH);
        end
    end

    assign pulse = (remain != '0);

    // R10: a pulse only begins after a permitted request
    assert_wake_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(req && allow));

    // R11: a withdrawn permission ends the pulse at once
    assert_wake_cut_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |=> !pulse);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic batt_good,
    input  logic io_good,
    input  logic on_req,
    input  logic off_req,
    input  logic settle_done,
    output logic settle_run,
    output logic wake_allow,
    output logic mod_en,
    output logic mod_rst_n,
    output logic ready,
    output logic seq_error
);
    pwr_state_t state, nxt;
    logic       err_set;
    logic       supplies_ok;
    logic       order_bad;

    assign supplies_ok = batt_good && io_good;
    assign order_bad   = io_good && !batt_good;

    // Next-state decision
    always_comb begin
        nxt     = state;
        err_set = 1'b0;
        unique case (state)
            PS_OFF: begin
                if (on_req) nxt = PS_WAIT_SUP;
            end
            PS_WAIT_SUP: begin
                if (order_bad) begin
                    err_set = 1'b1;
                    nxt     = PS_OFF;
                end else if (off_req) begin
                    nxt = PS_OFF;
                end else if (supplies_ok) begin
                    nxt = PS_ENABLE;
                end
            end
            PS_ENABLE: begin
                if (!supplies_ok) begin
                    err_set = 1'b1;
                    nxt     = PS_OFF;
                end else if (off_req) begin
                    nxt = PS_PDOWN;
                end else begin
                    nxt = PS_SETTLE;
                end
            end
            PS_SETTLE: begin
                if (!supplies_ok) begin
                    err_set = 1'b1;
                    nxt     = PS_OFF;
                end else if (off_req) begin
                    nxt = PS_PDOWN;
                end else if (settle_done) begin
                    nxt = PS_READY;
                end
            end
            PS_READY: begin
                if (!supplies_ok) begin
                    err_set = 1'b1;
                    nxt     = PS_OFF;
                end else if (off_req) begin
                    nxt = PS_PDOWN;
                end
            end
            PS_PDOWN: begin
                if (order_bad) begin
                    err_set = 1'b1;
                    nxt     = PS_OFF;
                end else if (!io_good) begin
                    nxt = PS_OFF;
                end
            end
            default: nxt = PS_OFF;
        endcase
    end

    assign settle_run = (state == PS_SETTLE);
    assign wake_allow = (state == PS_READY) && (nxt == PS_READY);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_OFF;
        else        state <= nxt;
    end

    // Registered outputs, aligned with the state they belong to
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_en    <= 1'b0;
            mod_rst_n <= 1'b0;
            ready     <= 1'b0;
            seq_error <= 1'b0;
        end else begin
            mod_en    <= state_powered(nxt);
            mod_rst_n <= (nxt == PS_READY);
            ready     <= (nxt == PS_READY) && (state == PS_READY);
            seq_error <= seq_error || err_set;
        end
    end

    // R2: enable rises only after both rails were seen good
    assert_enable_after_supplies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_en) |-> $past(batt_good && io_good));

    // R4: reset is never released while the module is disabled
    assert_reset_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mod_rst_n |-> mod_en);

    // R5: ready follows a reset release that already happened
    assert_ready_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(mod_rst_n));

    // R6: a rail loss while powered shuts the module down and flags it
    assert_fault_shutdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_powered(state) && !supplies_ok) |=> (!mod_en && !mod_rst_n && seq_error));

    // R7: a power-off request drops enable and reset together
    assert_off_drops_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_powered(state) && supplies_ok && off_req) |=> (!mod_en && !mod_rst_n));

    // R9: the error flag only clears through reset
    assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_error |=> seq_error);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int CLK_HZ      = 125_000_000,
    parameter int SETTLE_NS   = 5_000_000,
    parameter int WAKE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic batt_good,
    input  logic io_good,
    input  logic pwr_on_req,
    input  logic pwr_off_req,
    input  logic wake_req,
    output logic mod_enable,
    output logic mod_reset_n,
    output logic mod_wake,
    output logic ready,
    output logic seq_error
);
    localparam int SETTLE_CYCLES = settle_count(CLK_HZ, SETTLE_NS);

    logic settle_run;
    logic settle_done;
    logic wake_allow;

    pwr_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .batt_good   (batt_good),
        .io_good     (io_good),
        .on_req      (pwr_on_req),
        .off_req     (pwr_off_req),
        .settle_done (settle_done),
        .settle_run  (settle_run),
        .wake_allow  (wake_allow),
        .mod_en      (mod_enable),
        .mod_rst_n   (mod_reset_n),
        .ready       (ready),
        .seq_error   (seq_error)
    );

    pwr_settle_timer #(
        .CYCLES (SETTLE_CYCLES)
    ) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settle_run),
        .done  (settle_done)
    );

    pwr_wake_pulse #(
        .WIDTH (WAKE_CYCLES)
    ) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .allow (wake_allow),
        .req   (wake_req),
        .pulse (mod_wake)
    );

    // R10: the wake line is quiet whenever the module is not enabled
    assert_wake_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mod_wake |-> (mod_enable && mod_reset_n));

endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic batt_good = 1'b0, io_good = 1'b0;
    logic pwr_on_req = 1'b0, pwr_off_req = 1'b0, wake_req = 1'b0;
    logic mod_enable, mod_reset_n, mod_wake, ready, seq_error;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // 1 MHz nominal with 3 us settle gives SETTLE_CYCLES = 3; pulse width 2
    pwr_seq_ctrl #(
        .CLK_HZ      (1_000_000),
        .SETTLE_NS   (3000),
        .WAKE_CYCLES (2)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .batt_good   (batt_good),
        .io_good     (io_good),
        .pwr_on_req  (pwr_on_req),
        .pwr_off_req (pwr_off_req),
        .wake_req    (wake_req),
        .mod_enable  (mod_enable),
        .mod_reset_n (mod_reset_n),
        .mod_wake    (mod_wake),
        .ready       (ready),
        .seq_error   (seq_error)
    );

    // Row bits: batt io on off wake | enable reset_n ready error wake_out
    localparam int NVEC = 17;
    localparam logic [9:0] VEC [0:NVEC-1] = '{
        10'b00000_00000,  // idle in OFF
        10'b10100_00000,  // on request, battery only -> WAIT_SUPPLIES
        10'b10001_00000,  // still waiting; wake ignored outside READY
        10'b11000_10000,  // both good -> ENABLE, enable rises
        10'b11000_10000,  // SETTLE
        10'b11001_10000,  // SETTLE; wake ignored
        10'b11000_10000,  // SETTLE
        10'b11000_11000,  // READY, reset released 4 cycles after enable
        10'b11000_11100,  // ready follows one cycle later
        10'b11001_11101,  // wake pulse starts
        10'b11001_11101,  // held request ignored, pulse continues
        10'b11000_11100,  // pulse ended after two cycles
        10'b11000_11100,
        10'b11010_00000,  // off request -> POWER_DOWN
        10'b11000_00000,  // I/O rail still up, hold
        10'b10000_00000,  // I/O rail gone -> OFF
        10'b00000_00000   // battery gone, no error
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, return at the next falling edge
    task automatic apply(input logic b, input logic i, input logic on,
                         input logic off, input logic wk);
        batt_good   = b;
        io_good     = i;
        pwr_on_req  = on;
        pwr_off_req = off;
        wake_req    = wk;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        batt_good = 1'b0; io_good = 1'b0;
        pwr_on_req = 1'b0; pwr_off_req = 1'b0; wake_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bring_up();
        apply(1, 1, 1, 0, 0);
        apply(1, 1, 0, 0, 0);
        repeat (5) apply(1, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        // R1: outputs during reset
        chk("R1 enable in reset", mod_enable, 1'b0);
        chk("R1 reset_n in reset", mod_reset_n, 1'b0);
        do_reset();
        chk("R1 enable after reset", mod_enable, 1'b0);
        chk("R1 reset_n after reset", mod_reset_n, 1'b0);
        chk("R1 ready after reset", ready, 1'b0);
        chk("R1 error after reset", seq_error, 1'b0);
        chk("R1 wake after reset", mod_wake, 1'b0);

        // Table walk: R2 R4 R5 R7 R8 R10
        for (int k = 0; k < NVEC; k++) begin
            logic [9:0] v;
            v = VEC[k];
            apply(v[9], v[8], v[7], v[6], v[5]);
            chk($sformatf("vector %0d R2 R4 enable", k), mod_enable, v[4]);
            chk($sformatf("vector %0d R4 reset_n", k), mod_reset_n, v[3]);
            chk($sformatf("vector %0d R5 ready", k), ready, v[2]);
            chk($sformatf("vector %0d R8 error", k), seq_error, v[1]);
            chk($sformatf("vector %0d R10 wake", k), mod_wake, v[0]);
        end

        // R3: I/O rail before battery while waiting
        apply(0, 1, 1, 0, 0);
        chk("R3 waiting, enable low", mod_enable, 1'b0);
        apply(0, 1, 0, 0, 0);
        chk("R3 order error set", seq_error, 1'b1);
        chk("R3 enable stays low", mod_enable, 1'b0);
        apply(0, 0, 0, 0, 0);
        chk("R3 back in OFF", mod_enable, 1'b0);

        // R9: sticky error does not block power-up
        bring_up();
        chk("R9 powered with error set", mod_enable, 1'b1);
        chk("R9 ready with error set", ready, 1'b1);
        chk("R9 error still set", seq_error, 1'b1);

        // R11: leaving READY cuts a running wake pulse
        apply(1, 1, 0, 0, 1);
        chk("R10 wake started", mod_wake, 1'b1);
        apply(1, 1, 0, 1, 0);
        chk("R11 wake cut on exit", mod_wake, 1'b0);
        chk("R7 enable dropped", mod_enable, 1'b0);
        apply(1, 0, 0, 0, 0);
        apply(0, 0, 0, 0, 0);

        // R9: reset clears the error
        do_reset();
        chk("R9 error cleared by reset", seq_error, 1'b0);

        // R6: rail loss in READY wins over an off request
        bring_up();
        chk("R6 ready before fault", ready, 1'b1);
        apply(1, 0, 0, 1, 0);
        chk("R6 fault error", seq_error, 1'b1);
        chk("R6 fault enable", mod_enable, 1'b0);
        chk("R6 fault reset_n", mod_reset_n, 1'b0);
        chk("R6 fault ready", ready, 1'b0);
        apply(1, 1, 0, 0, 0);
        chk("R6 went to OFF", mod_enable, 1'b0);

        // R7: off request during SETTLE
        do_reset();
        apply(1, 1, 1, 0, 0);
        apply(1, 1, 0, 0, 0);
        chk("R7 enabled", mod_enable, 1'b1);
        apply(1, 1, 0, 0, 0);
        apply(1, 1, 0, 1, 0);
        chk("R7 enable low in settle", mod_enable, 1'b0);
        chk("R7 reset_n low in settle", mod_reset_n, 1'b0);
        chk("R7 no error", seq_error, 1'b0);

        // R8: battery falling first during POWER_DOWN
        apply(0, 1, 0, 0, 0);
        chk("R8 battery first error", seq_error, 1'b1);
        chk("R8 enable low", mod_enable, 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule